// File: doc/BRIEF.md
# Punched-Card Reader Word Sequencer

This block stands in for a card reader that is attached to an I/O channel. A read select starts card motion. After a start delay the block checks whether a card is present. If one is, it takes the card image as 72 twelve-bit column codes through a column port. It turns the columns into 24 row-oriented 36-bit words and hands them to the channel one at a time.

Word delivery is paced so that it looks like real card motion. The gaps after words alternate between a short one and a long one, chosen by the parity of the word pointer. The 24th word carries an end-of-record flag. A stop delay follows. The block then starts on the next card if the channel is still connected, or goes idle if it is not. When no card is present at load time, the block raises end-of-file and returns to idle without sending any data. A parameter selects the column format: either one 12-bit code per beat, or two 6-bit characters per column.

Top module: `card_rdr_seq`

## Requirements
- R1: After reset the block is idle: col_req, word_valid, word_last, eof, sel_stall and sel_illegal are all low.
- R2: sel_op encodes 00 as read, 01 as no-data and 10 or 11 as illegal. An illegal select raises sel_illegal in the cycle after it is sampled. A no-data select raises no flag. Neither of them starts the card motion.
- R3: A read select sampled while the block is not idle raises sel_stall in the next cycle. It has no effect on the card in progress.
- R4: From idle, a read select starts the start delay. If card_avail is high, col_req rises START_DLY+1 cycles after the select edge.
- R5: If card_avail is low at load time, eof pulses for one cycle at the point where col_req would have risen. No word is sent and the block returns to idle, so a later read select is accepted without a stall.
- R6: In whole-code mode each accepted beat is one column, with col_data bit 11 = row 12, bit 10 = row 11, bit 9 = row 0 and bits 8 down to 0 = rows 1 to 9. In character-pair mode a column is two beats on col_data[5:0], with the first beat giving the upper six bits.
- R7: Words are delivered in index order 0 to 23. Word w holds row index r = w/2 (row index r is code bit r). Its bit 35-(c mod 36) is that row's bit of column c, with c taken from columns 0 to 35 when w is even and from columns 36 to 71 when w is odd.
- R8: The gap from word w to word w+1 is GAP_SHORT cycles when w+1 is odd and GAP_LONG cycles when w+1 is even.
- R9: word_last is high on the 24th word only, and only together with word_valid.
- R10: If chan_conn is high when the stop delay ends, col_req for the next card rises STOP_DLY+2 cycles after the last word. If chan_conn is low, the block goes idle and a later read select is accepted without a stall.
- R11: Column beats offered while col_req is low are ignored and do not change the image that is delivered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Select command strobe |
| sel_op | input | 2 | Select code: 00 read, 01 no-data, 1x illegal |
| sel_stall | output | 1 | Pulse: read select while busy |
| sel_illegal | output | 1 | Pulse: illegal select code |
| card_avail | input | 1 | A card is present for the next load |
| col_req | output | 1 | Block is accepting column beats |
| col_valid | input | 1 | Column beat strobe |
| col_data | input | CODE_W | Column code, or a 6-bit character in [5:0] |
| chan_conn | input | 1 | Channel still connected at card end |
| word_valid | output | 1 | One-cycle word strobe |
| word_data | output | WORD_W | Row word |
| word_last | output | 1 | End-of-record marker on the final word |
| eof | output | 1 | Pulse: no card at load time |

## Verification
Each result has a fixed due cycle. Select flags appear in the cycle right after the select edge. col_req or eof appear START_DLY+1 cycles after a read select, and again STOP_DLY+2 cycles after the last word of a card. The gap between consecutive words is GAP_SHORT or GAP_LONG, set by the parity of the next word index. The bench keeps a cycle counter, samples every output on the falling edge and stamps each word and eof with the cycle it appeared in. It then checks the differences between those stamps against the due counts, and it checks word contents against an image it computes from the column codes. A second instance in character-pair mode runs in lockstep on the same cards, with its beats aligned so that both finish loading on the same edge.

// File: rtl/card_rdr_pkg.sv
package card_rdr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_FEED,
      ST_LOAD,
      ST_XFER,
      ST_STOP,
      ST_END
   } rdr_state_t;

   localparam logic [1:0] SEL_READ   = 2'b00;
   localparam logic [1:0] SEL_NODATA = 2'b01;

endpackage

// File: rtl/card_col_assembler.sv
module card_col_assembler #(
   parameter int CODE_W    = 12,
   parameter bit CHAR_PAIR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_data,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code
);

   if (!CHAR_PAIR) begin : g_whole
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
         end else begin
            out_valid <= en & in_valid & ~clr;
            if (en & in_valid) out_code <= in_data;
         end
      end
   end else begin : g_pair
      localparam int HALF = CODE_W / 2;
      logic            phase;
      logic [HALF-1:0] upper;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
            phase     <= 1'b0;
            upper     <= '0;
         end else begin
            out_valid <= 1'b0;
            if (clr) begin
               phase <= 1'b0;
            end else if (en & in_valid) begin
               if (!phase) begin
                  upper <= in_data[HALF-1:0];
                  phase <= 1'b1;
               end else begin
                  out_code  <= {upper, in_data[HALF-1:0]};
                  out_valid <= 1'b1;
                  phase     <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/card_row_bank.sv
module card_row_bank #(
   parameter int NROW   = 12,
   parameter int WORD_W = 36,
   parameter int NHALF  = 2
) (
   input  logic                              clk,
   input  logic                              shift_en,
   input  logic [$clog2(NHALF)-1:0]          half_sel,
   input  logic [NROW-1:0]                   code,
   input  logic [$clog2(NROW*NHALF)-1:0]     rd_idx,
   output logic [WORD_W-1:0]                 rd_word
);

   localparam int NWORD  = NROW * NHALF;
   localparam int HSEL_W = $clog2(NHALF);

   logic [WORD_W-1:0] words [NWORD];

   for (genvar r = 0; r < NROW; r++) begin : g_row
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk) begin
            if (shift_en && half_sel == HSEL_W'(h))
               q <= {q[WORD_W-2:0], code[r]};
         end
         assign words[r*NHALF + h] = q;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NWORD; i++)
         if (rd_idx == ($clog2(NWORD))'(i)) rd_word = words[i];
   end

endmodule

// File: rtl/card_pace_timer.sv
module card_pace_timer #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (load)     cnt <= load_val;
      else if (cnt != 0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/card_rdr_seq.sv
module card_rdr_seq
   import card_rdr_pkg::*;
#(
   parameter int NCOL      = 72,
   parameter int CODE_W    = 12,
   parameter int WORD_W    = 36,
   parameter bit CHAR_PAIR = 1'b0,
   parameter int START_DLY = 27500,
   parameter int STOP_DLY  = 27500,
   parameter int GAP_SHORT = 150,
   parameter int GAP_LONG  = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_valid,
   input  logic [1:0]        sel_op,
   output logic              sel_stall,
   output logic              sel_illegal,
   input  logic              card_avail,
   output logic              col_req,
   input  logic              col_valid,
   input  logic [CODE_W-1:0] col_data,
   input  logic              chan_conn,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              word_last,
   output logic              eof
);

   localparam int NHALF  = NCOL / WORD_W;
   localparam int NWORD  = CODE_W * NHALF;
   localparam int IDX_W  = $clog2(NWORD);
   localparam int HSEL_W = $clog2(NHALF);
   localparam int CPOS_W = $clog2(WORD_W);
   localparam int MAX_AB = (START_DLY > STOP_DLY) ? START_DLY : STOP_DLY;
   localparam int MAX_CD = (GAP_SHORT > GAP_LONG) ? GAP_SHORT : GAP_LONG;
   localparam int MAXD   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W  = $clog2(MAXD + 1);

   localparam logic [CNT_W-1:0] T_START = CNT_W'(START_DLY - 1);
   localparam logic [CNT_W-1:0] T_STOP  = CNT_W'(STOP_DLY - 1);
   localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(GAP_SHORT - 1);
   localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(GAP_LONG - 1);

   if (START_DLY < 1 || STOP_DLY < 1) begin : g_bad_delay
      $error("card_rdr_seq: start and stop delays must be at least 1");
   end
   if (GAP_SHORT < 2 || GAP_LONG < 2) begin : g_bad_gap
      $error("card_rdr_seq: word gaps must be at least 2");
   end
   if (NCOL % WORD_W != 0 || NHALF < 2) begin : g_bad_cols
      $error("card_rdr_seq: NCOL must be a multiple of WORD_W, at least two words");
   end
   if (CHAR_PAIR && (CODE_W % 2 != 0)) begin : g_bad_pair
      $error("card_rdr_seq: character-pair mode needs an even code width");
   end

   rdr_state_t        state;
   logic [IDX_W-1:0]  ptr;
   logic [CPOS_W-1:0] colpos;
   logic [HSEL_W-1:0] half;
   logic              code_valid;
   logic [CODE_W-1:0] code;
   logic [WORD_W-1:0] rd_word;
   logic              t_zero;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              sel_rd;
   logic              ptr_last;
   logic              shift_en;

   assign sel_rd   = sel_valid && (sel_op == SEL_READ);
   assign ptr_last = (ptr == IDX_W'(NWORD - 1));
   assign col_req  = (state == ST_LOAD);
   assign shift_en = code_valid && (state == ST_LOAD);

   always_comb begin
      t_load = 1'b0;
      t_val  = T_START;
      if (state == ST_IDLE && sel_rd) begin
         t_load = 1'b1;
      end else if (state == ST_XFER && t_zero) begin
         t_load = 1'b1;
         if (ptr_last)    t_val = T_STOP;
         else if (ptr[0]) t_val = T_LONG;
         else             t_val = T_SHORT;
      end
   end

   card_pace_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   card_col_assembler #(.CODE_W(CODE_W), .CHAR_PAIR(CHAR_PAIR)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (state == ST_FEED),
      .en        (col_req),
      .in_valid  (col_valid),
      .in_data   (col_data),
      .out_valid (code_valid),
      .out_code  (code)
   );

   card_row_bank #(.NROW(CODE_W), .WORD_W(WORD_W), .NHALF(NHALF)) u_bank (
      .clk      (clk),
      .shift_en (shift_en),
      .half_sel (half),
      .code     (code),
      .rd_idx   (ptr),
      .rd_word  (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         ptr         <= '0;
         colpos      <= '0;
         half        <= '0;
         word_valid  <= 1'b0;
         word_data   <= '0;
         word_last   <= 1'b0;
         eof         <= 1'b0;
         sel_stall   <= 1'b0;
         sel_illegal <= 1'b0;
      end else begin
         word_valid  <= 1'b0;
         word_last   <= 1'b0;
         eof         <= 1'b0;
         sel_stall   <= sel_rd && (state != ST_IDLE);
         sel_illegal <= sel_valid && sel_op[1];
         case (state)
            ST_IDLE:  if (sel_rd) state <= ST_START;
            ST_START: if (t_zero) state <= ST_FEED;
            ST_FEED: begin
               if (card_avail) begin
                  state  <= ST_LOAD;
                  colpos <= '0;
                  half   <= '0;
               end else begin
                  eof   <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            ST_LOAD: begin
               if (code_valid) begin
                  if (colpos == CPOS_W'(WORD_W - 1)) begin
                     colpos <= '0;
                     if (half == HSEL_W'(NHALF - 1)) begin
                        state <= ST_XFER;
                        ptr   <= '0;
                     end else begin
                        half <= half + 1'b1;
                     end
                  end else begin
                     colpos <= colpos + 1'b1;
                  end
               end
            end
            ST_XFER: begin
               if (t_zero) begin
                  word_valid <= 1'b1;
                  word_data  <= rd_word;
                  word_last  <= ptr_last;
                  ptr        <= ptr + 1'b1;
                  if (ptr_last) state <= ST_STOP;
               end
            end
            ST_STOP:  if (t_zero) state <= ST_END;
            ST_END:   state <= chan_conn ? ST_FEED : ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/card_rdr_seq_chk.sv
module card_rdr_seq_chk #(
   parameter int NWORD = 24
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_valid,
   input logic [1:0] sel_op,
   input logic       sel_stall,
   input logic       sel_illegal,
   input logic       col_req,
   input logic       word_valid,
   input logic       word_last,
   input logic       eof
);

   int unsigned wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       wcnt <= 0;
      else if (word_valid && word_last) wcnt <= 0;
      else if (word_valid)              wcnt <= wcnt + 1;
   end

   p_illegal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_op[1] |=> sel_illegal);

   p_nodata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_op == 2'b01 |=> !sel_illegal && !sel_stall);

   p_err_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_stall, sel_illegal}));

   p_busy_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid && sel_op == 2'b00 && col_req |=> sel_stall);

   p_eof_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> !col_req && !word_valid);

   p_no_word_in_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      col_req |-> !word_valid);

   p_word_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   p_last_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_last |-> word_valid);

   p_last_on_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && word_last |-> wcnt == NWORD - 1);

endmodule

bind card_rdr_seq card_rdr_seq_chk #(.NWORD(NWORD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_valid   (sel_valid),
   .sel_op      (sel_op),
   .sel_stall   (sel_stall),
   .sel_illegal (sel_illegal),
   .col_req     (col_req),
   .word_valid  (word_valid),
   .word_last   (word_last),
   .eof         (eof)
);

// File: tb/card_rdr_seq_tb_top.sv
module card_rdr_seq_tb_top;

   localparam int S  = 20;
   localparam int P  = 30;
   localparam int GS = 3;
   localparam int GL = 7;
   localparam int NW = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_valid = 1'b0;
   logic [1:0] sel_op = 2'b00;
   logic card_avail = 1'b0;
   logic chan_conn = 1'b0;
   logic colv_f = 1'b0, colv_c = 1'b0;
   logic [11:0] cold_f = '0, cold_c = '0;

   logic stall_f, ill_f, req_f, wv_f, wl_f, eof_f;
   logic stall_c, ill_c, req_c, wv_c, wl_c, eof_c;
   logic [35:0] wd_f, wd_c;

   always #10 clk = ~clk;

   card_rdr_seq #(.CHAR_PAIR(1'b0), .START_DLY(S), .STOP_DLY(P),
                  .GAP_SHORT(GS), .GAP_LONG(GL)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_op(sel_op),
      .sel_stall(stall_f), .sel_illegal(ill_f), .card_avail(card_avail),
      .col_req(req_f), .col_valid(colv_f), .col_data(cold_f),
      .chan_conn(chan_conn), .word_valid(wv_f), .word_data(wd_f),
      .word_last(wl_f), .eof(eof_f));

   card_rdr_seq #(.CHAR_PAIR(1'b1), .START_DLY(S), .STOP_DLY(P),
                  .GAP_SHORT(GS), .GAP_LONG(GL)) dut_c_i (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_op(sel_op),
      .sel_stall(stall_c), .sel_illegal(ill_c), .card_avail(card_avail),
      .col_req(req_c), .col_valid(colv_c), .col_data(cold_c),
      .chan_conn(chan_conn), .word_valid(wv_c), .word_data(wd_c),
      .word_last(wl_c), .eof(eof_c));

   int cyc = 0;
   int nvec = 0;
   int nfail = 0;
   int nw = 0, nwc = 0;
   int eof_t = -1;
   logic [35:0] wd  [128];
   logic [35:0] wdc [128];
   bit          wl  [128];
   int          wt  [128];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (wv_f && nw < 128) begin
         wd[nw] = wd_f; wl[nw] = wl_f; wt[nw] = cyc; nw = nw + 1;
      end
      if (wv_c && nwc < 128) begin
         wdc[nwc] = wd_c; nwc = nwc + 1;
      end
      if (eof_f) eof_t = cyc;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   endtask

   function automatic logic [11:0] colcode(input int seed, input int c);
      logic [31:0] x;
      if (seed == 0) return 12'hFFF;
      if (seed == 2) return 12'(1) << (c % 12);
      x = (c + 1) * 40503 + seed * 9973;
      return x[15:4] ^ x[11:0];
   endfunction

   function automatic logic [35:0] exp_word(input int seed, input int w);
      logic [35:0] e;
      logic [11:0] k;
      for (int b = 0; b < 36; b++) begin
         k = colcode(seed, (w % 2) * 36 + 35 - b);
         e[b] = k[w / 2];
      end
      return e;
   endfunction

   task automatic do_select(input logic [1:0] op, output int t);
      sel_valid = 1'b1; sel_op = op;
      @(negedge clk);
      sel_valid = 1'b0; sel_op = 2'b00;
      t = cyc;
   endtask

   task automatic wait_req(output int t);
      int lim = 0;
      while (!(req_f && req_c) && lim < 2000) begin
         @(negedge clk); lim++;
      end
      t = cyc;
   endtask

   task automatic feed_card(input int seed);
      logic [11:0] k;
      for (int c = 0; c < 72; c++) begin
         k = colcode(seed, c);
         colv_f = 1'b0;
         colv_c = 1'b1; cold_c = {6'b0, k[11:6]};
         @(negedge clk);
         colv_f = 1'b1; cold_f = k;
         colv_c = 1'b1; cold_c = {6'b0, k[5:0]};
         @(negedge clk);
      end
      colv_f = 1'b0; colv_c = 1'b0;
   endtask

   task automatic wait_words(input int tf, input int tc);
      int lim = 0;
      while ((nw < tf || nwc < tc) && lim < 3000) begin
         @(negedge clk); lim++;
      end
   endtask

   task automatic check_card(input int seed, input int bf, input int bc);
      logic [35:0] e;
      chk(nw >= bf + NW, "R7", "word count", nw - bf, NW);
      for (int w = 0; w < NW; w++) begin
         e = exp_word(seed, w);
         chk(wd[bf+w] == e, "R7", $sformatf("whole-mode word %0d", w), wd[bf+w], e);
         chk(wdc[bc+w] == e, "R6", $sformatf("pair-mode word %0d", w), wdc[bc+w], e);
         chk(wl[bf+w] == (w == NW - 1), "R9", $sformatf("last flag word %0d", w),
             wl[bf+w], (w == NW - 1));
         if (w < NW - 1)
            chk(wt[bf+w+1] - wt[bf+w] == (((w + 1) % 2) ? GS : GL), "R8",
                $sformatf("gap after word %0d", w), wt[bf+w+1] - wt[bf+w],
                (((w + 1) % 2) ? GS : GL));
      end
   endtask

   task automatic t_reset();
      chk(!req_f && !wv_f && !wl_f, "R1", "data outputs idle", {req_f, wv_f, wl_f}, 0);
      chk(!eof_f && !stall_f && !ill_f, "R1", "flags idle", {eof_f, stall_f, ill_f}, 0);
   endtask

   task automatic t_select_codes();
      int t;
      bit moved = 1'b0;
      do_select(2'b10, t);
      chk(ill_f == 1'b1, "R2", "illegal 10 flag", ill_f, 1);
      chk(stall_f == 1'b0, "R2", "no stall on 10", stall_f, 0);
      do_select(2'b11, t);
      chk(ill_f == 1'b1, "R2", "illegal 11 flag", ill_f, 1);
      do_select(2'b01, t);
      chk(!ill_f && !stall_f, "R2", "no-data select silent", {ill_f, stall_f}, 0);
      for (int i = 0; i < S + 6; i++) begin
         @(negedge clk);
         if (req_f || eof_f) moved = 1'b1;
      end
      chk(!moved, "R2", "no card motion after non-read selects", moved, 0);
   endtask

   task automatic t_eof_start();
      int t;
      bit req_seen = 1'b0;
      card_avail = 1'b0;
      eof_t = -1;
      do_select(2'b00, t);
      for (int i = 0; i < S + 6; i++) begin
         @(negedge clk);
         if (req_f) req_seen = 1'b1;
      end
      chk(eof_t - t == S + 1, "R5", "eof delay after read", eof_t - t, S + 1);
      chk(!req_seen, "R5", "no column request on empty hopper", req_seen, 0);
      chk(nw == 0, "R5", "no words on empty hopper", nw, 0);
   endtask

   task automatic t_card_chain();
      int t, tr, bf, bc, tl;
      bit req_seen = 1'b0;
      card_avail = 1'b1;
      chan_conn  = 1'b1;
      do_select(2'b00, t);
      chk(stall_f == 1'b0, "R5", "read accepted after eof", stall_f, 0);
      colv_f = 1'b1; cold_f = 12'hABC;
      colv_c = 1'b1; cold_c = 12'h02A;
      repeat (6) @(negedge clk);
      colv_f = 1'b0; colv_c = 1'b0;
      wait_req(tr);
      chk(tr - t == S + 1, "R4", "column request delay", tr - t, S + 1);
      bf = nw; bc = nwc;
      feed_card(1);
      wait_words(bf + 1, bc + 1);
      do_select(2'b00, t);
      chk(stall_f == 1'b1, "R3", "stall on busy read", stall_f, 1);
      wait_words(bf + NW, bc + NW);
      check_card(1, bf, bc);
      tl = wt[bf + NW - 1];
      wait_req(tr);
      chk(tr - tl == P + 2, "R10", "restart delay after last word", tr - tl, P + 2);
      bf = nw; bc = nwc;
      feed_card(2);
      chan_conn = 1'b0;
      wait_words(bf + NW, bc + NW);
      check_card(2, bf, bc);
      for (int i = 0; i < P + 10; i++) begin
         @(negedge clk);
         if (req_f) req_seen = 1'b1;
      end
      chk(!req_seen, "R10", "idle when channel dropped", req_seen, 0);
      chan_conn = 1'b1;
      do_select(2'b00, t);
      chk(stall_f == 1'b0, "R10", "read accepted after idle", stall_f, 0);
      wait_req(tr);
      chk(tr - t == S + 1, "R4", "second start delay", tr - t, S + 1);
      bf = nw; bc = nwc;
      feed_card(0);
      wait_words(bf + NW, bc + NW);
      card_avail = 1'b0;
      check_card(0, bf, bc);
      tl = wt[bf + NW - 1];
      eof_t = -1;
      repeat (P + 6) @(negedge clk);
      chk(eof_t - tl == P + 2, "R5", "eof at restart with empty hopper", eof_t - tl, P + 2);
      chk(req_f == 1'b0, "R5", "no request after eof", req_f, 0);
      chk(nw == bf + NW, "R11", "no extra words", nw, bf + NW);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select_codes();
      t_eof_start();
      t_card_chain();
      finish_run();
   end

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", cyc, 0);
      finish_run();
   end

endmodule